// File: doc/BRIEF.md
# Hardwired Micro-Operation Sequencer

This block is the control unit of a small single-bus processor, together with the register datapath that it steers. It holds a program counter, a memory address register, a memory buffer register, an instruction register, one accumulator and an adder. A 2-bit phase register and a step counter are decoded with the opcode into one control word per clock. Each clock performs one register transfer, and the block walks through fetch, indirect, execute and interrupt phases.

Instruction words are 16 bits wide. Bit 15 is the indirect flag, bits 14:12 hold the opcode and bits 11:0 hold the operand address. The opcodes are:

- 0: add the memory word to the accumulator.
- 1: increment the memory word and skip the next instruction if the result is zero.
- 2: branch and save the return address.
- 7: enable interrupts.
- 3 to 6: no operation.

Memory sits outside the block on a synchronous port. The address is always taken from the memory address register, and read data returns one clock after the read strobe.

A pending interrupt request is taken at the end of an execute phase, but only while interrupts are enabled. The interrupt phase saves the program counter into word 0, continues at word 1 and disables further interrupts.

Top module: `uop_sequencer`

## Requirements
- R1: After reset, phase_o is 00, pc_o is 0, acc_o is 0 and ien_o is 0. phase_o encodes the phase as 00 fetch, 01 indirect, 10 execute, 11 interrupt.
- R2: The step counter restarts at every phase change. The phases last the following number of clocks: fetch 4, indirect 4, execute 4 for opcode 0, 5 for opcode 1, 2 for opcode 2 and 1 for any other opcode, interrupt 2.
- R3: Fetch loads MAR from PC, reads memory at that address, increments PC by one in the same step as the read, then loads the word into IR. Bits [15] (indirect), [14:12] (opcode) and [11:0] (address) are decoded from IR.
- R4: Opcode 0 sets the accumulator to the accumulator plus mem[X], modulo 2^16.
- R5: Opcode 1 writes mem[X]+1 (modulo 2^16) back to X. When the new value is zero, PC is incremented once more, so the next instruction is skipped.
- R6: Opcode 2 writes the address of the following instruction (zero-extended) into X and continues execution at X+1.
- R7: With bit 15 set, an indirect phase reads mem[X] and replaces the IR address field with its low 12 bits before execute runs. The phase order is then fetch, indirect, execute.
- R8: Opcode 7 sets the interrupt enable, and its effect is first seen at the end of the following instruction. Opcodes 3 to 6 change no register other than PC and write no memory.
- R9: When an execute phase ends with the interrupt enable set and irq_i high, an interrupt phase writes PC into word 0, sets PC to 1 and clears the enable. While the enable is clear, irq_i is ignored.
- R10: mem_addr_o always shows MAR. Read data is taken one clock after mem_rd_o. mem_rd_o and mem_wr_o are never high in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 1 | Interrupt request level |
| mem_addr_o | output | 12 | Memory address (from MAR) |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 16 | Write data (from MBR) |
| mem_rdata_i | input | 16 | Read data, valid one clock after the read strobe |
| phase_o | output | 2 | Current phase code |
| pc_o | output | 12 | Program counter |
| acc_o | output | 16 | Accumulator |
| ien_o | output | 1 | Interrupt enable |

## Verification
The hardest situation to reach from the ports is an interrupt entry that follows a skip or an indirect operand, with the return address in word 0 then being overwritten by later code. The interrupt enable is only set by an instruction, and interrupts are only taken at an instruction end, so random programs of several hundred instructions are run with irq_i held high. Their code mixes the enable opcode, indirect words, self-modifying increments and branches. Every instruction end is compared with an instruction-level model in the bench for PC, accumulator and clock count, and the whole memory image is compared at the end of each run. A directed program pins down the wrap of the adder, the zero-skip, the return address and the deferred effect of the enable.

// File: rtl/uop_pkg.sv
package uop_pkg;

  typedef enum logic [1:0] {
    PH_FETCH = 2'b00,
    PH_INDIR = 2'b01,
    PH_EXEC  = 2'b10,
    PH_INTR  = 2'b11
  } phase_e;

  localparam int OP_ADD = 0;
  localparam int OP_ISZ = 1;
  localparam int OP_BSA = 2;
  localparam int OP_ENI = 7;

  typedef struct packed {
    logic mar_pc;
    logic mar_ir;
    logic mar_zero;
    logic mbr_mem;
    logic mbr_pc;
    logic mbr_inc;
    logic ir_load;
    logic ir_addr_load;
    logic pc_inc;
    logic pc_jump;
    logic pc_one;
    logic pc_skip_z;
    logic acc_add;
    logic ien_set;
    logic ien_clr;
    logic mem_rd;
    logic mem_wr;
    logic last;
  } ctrl_t;

endpackage

// File: rtl/uop_opdec.sv
module uop_opdec #(
  parameter int OPW = 3,
  localparam int NOPS = 1 << OPW
) (
  input  logic [OPW-1:0]  op_i,
  output logic [NOPS-1:0] op_oh_o
);
  for (genvar i = 0; i < NOPS; i++) begin : g_line
    assign op_oh_o[i] = (op_i == OPW'(i));
  end
endmodule

// File: rtl/uop_timing.sv
module uop_timing
  import uop_pkg::*;
#(
  parameter int STEP_W    = 3,
  parameter int MAX_STEPS = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              last_i,
  input  phase_e            next_ph_i,
  output phase_e            phase_o,
  output logic [STEP_W-1:0] step_o
);
  phase_e            phase_q;
  logic [STEP_W-1:0] step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_FETCH;
      step_q  <= '0;
    end else if (last_i) begin
      phase_q <= next_ph_i;
      step_q  <= '0;
    end else begin
      step_q <= step_q + 1'b1;
    end
  end

  assign phase_o = phase_q;
  assign step_o  = step_q;

  p_step_clr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != $past(phase_q)) |-> (step_q == '0));

  p_step_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(step_q) < MAX_STEPS);
endmodule

// File: rtl/uop_ctrl.sv
module uop_ctrl
  import uop_pkg::*;
#(
  parameter int OPW    = 3,
  parameter int STEP_W = 3,
  localparam int NOPS  = 1 << OPW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  phase_e            phase_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [NOPS-1:0]   op_oh_i,
  input  logic              ind_i,
  input  logic              ien_i,
  input  logic              irq_i,
  output ctrl_t             ctrl_o,
  output phase_e            next_ph_o
);
  ctrl_t  c;
  phase_e nxt;
  phase_e exec_end;

  assign exec_end = (ien_i && irq_i) ? PH_INTR : PH_FETCH;

  always_comb begin
    c   = '0;
    nxt = phase_i;
    unique case (phase_i)
      PH_FETCH: begin
        case (step_i)
          STEP_W'(0): c.mar_pc = 1'b1;
          STEP_W'(1): begin c.mem_rd = 1'b1; c.pc_inc = 1'b1; end
          STEP_W'(2): c.mbr_mem = 1'b1;
          default: begin c.ir_load = 1'b1; c.last = 1'b1; end
        endcase
        if (c.last) nxt = ind_i ? PH_INDIR : PH_EXEC;
      end
      PH_INDIR: begin
        case (step_i)
          STEP_W'(0): c.mar_ir = 1'b1;
          STEP_W'(1): c.mem_rd = 1'b1;
          STEP_W'(2): c.mbr_mem = 1'b1;
          default: begin c.ir_addr_load = 1'b1; c.last = 1'b1; end
        endcase
        if (c.last) nxt = PH_EXEC;
      end
      PH_EXEC: begin
        if (op_oh_i[OP_ADD]) begin
          case (step_i)
            STEP_W'(0): c.mar_ir = 1'b1;
            STEP_W'(1): c.mem_rd = 1'b1;
            STEP_W'(2): c.mbr_mem = 1'b1;
            default: begin c.acc_add = 1'b1; c.last = 1'b1; end
          endcase
        end else if (op_oh_i[OP_ISZ]) begin
          case (step_i)
            STEP_W'(0): c.mar_ir = 1'b1;
            STEP_W'(1): c.mem_rd = 1'b1;
            STEP_W'(2): c.mbr_mem = 1'b1;
            STEP_W'(3): c.mbr_inc = 1'b1;
            default: begin c.mem_wr = 1'b1; c.pc_skip_z = 1'b1; c.last = 1'b1; end
          endcase
        end else if (op_oh_i[OP_BSA]) begin
          case (step_i)
            STEP_W'(0): begin c.mar_ir = 1'b1; c.mbr_pc = 1'b1; end
            default: begin c.mem_wr = 1'b1; c.pc_jump = 1'b1; c.last = 1'b1; end
          endcase
        end else if (op_oh_i[OP_ENI]) begin
          c.ien_set = 1'b1;
          c.last    = 1'b1;
        end else begin
          c.last = 1'b1;
        end
        if (c.last) nxt = exec_end;
      end
      PH_INTR: begin
        case (step_i)
          STEP_W'(0): begin c.mar_zero = 1'b1; c.mbr_pc = 1'b1; end
          default: begin c.mem_wr = 1'b1; c.pc_one = 1'b1; c.ien_clr = 1'b1; c.last = 1'b1; end
        endcase
        if (c.last) nxt = PH_FETCH;
      end
      default: begin
        c.last = 1'b1;
        nxt    = PH_FETCH;
      end
    endcase
  end

  assign ctrl_o    = c;
  assign next_ph_o = nxt;

  p_dec_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(op_oh_i));

  p_exec_no_int_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_EXEC && ctrl_o.last && !ien_i) |-> (next_ph_o == PH_FETCH));
endmodule

// File: rtl/uop_datapath.sv
module uop_datapath
  import uop_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  ctrl_t         ctrl_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic [AW-1:0] pc_o,
  output logic [DW-1:0] acc_o,
  output logic [DW-1:0] ir_o,
  output logic          ien_o
);
  logic [AW-1:0] pc_q, mar_q;
  logic [DW-1:0] mbr_q, ir_q, acc_q;
  logic          ien_q;
  logic [DW-1:0] alu_sum;
  logic          mbr_zero;

  assign alu_sum  = acc_q + mbr_q;
  assign mbr_zero = (mbr_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      mar_q <= '0;
      mbr_q <= '0;
      ir_q  <= '0;
      acc_q <= '0;
      ien_q <= 1'b0;
    end else begin
      if (ctrl_i.pc_one)                                 pc_q <= AW'(1);
      else if (ctrl_i.pc_jump)                           pc_q <= mar_q + 1'b1;
      else if (ctrl_i.pc_inc || (ctrl_i.pc_skip_z && mbr_zero)) pc_q <= pc_q + 1'b1;

      if (ctrl_i.mar_pc)        mar_q <= pc_q;
      else if (ctrl_i.mar_ir)   mar_q <= ir_q[AW-1:0];
      else if (ctrl_i.mar_zero) mar_q <= '0;

      if (ctrl_i.mbr_mem)      mbr_q <= mem_rdata_i;
      else if (ctrl_i.mbr_pc)  mbr_q <= DW'(pc_q);
      else if (ctrl_i.mbr_inc) mbr_q <= mbr_q + 1'b1;

      if (ctrl_i.ir_load)           ir_q <= mbr_q;
      else if (ctrl_i.ir_addr_load) ir_q[AW-1:0] <= mbr_q[AW-1:0];

      if (ctrl_i.acc_add) acc_q <= alu_sum;

      if (ctrl_i.ien_clr)      ien_q <= 1'b0;
      else if (ctrl_i.ien_set) ien_q <= 1'b1;
    end
  end

  assign mem_addr_o  = mar_q;
  assign mem_wdata_o = mbr_q;
  assign pc_o        = pc_q;
  assign acc_o       = acc_q;
  assign ir_o        = ir_q;
  assign ien_o       = ien_q;

  p_mar_src_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ctrl_i.mar_pc, ctrl_i.mar_ir, ctrl_i.mar_zero}));

  p_mbr_src_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ctrl_i.mbr_mem, ctrl_i.mbr_pc, ctrl_i.mbr_inc}));

  p_rd_then_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.mem_rd |=> ctrl_i.mbr_mem);
endmodule

// File: rtl/uop_sequencer.sv
module uop_sequencer
  import uop_pkg::*;
#(
  parameter int AW        = 12,
  parameter int DW        = 16,
  parameter int OPW       = 3,
  parameter int STEP_W    = 3,
  parameter int MAX_STEPS = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          irq_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [1:0]    phase_o,
  output logic [AW-1:0] pc_o,
  output logic [DW-1:0] acc_o,
  output logic          ien_o
);
  localparam int NOPS = 1 << OPW;

  phase_e            phase, next_ph;
  logic [STEP_W-1:0] step;
  logic [NOPS-1:0]   op_oh;
  logic [DW-1:0]     ir;
  ctrl_t             ctrl;

  uop_timing #(.STEP_W(STEP_W), .MAX_STEPS(MAX_STEPS)) u_timing (
    .clk_i, .rst_ni,
    .last_i   (ctrl.last),
    .next_ph_i(next_ph),
    .phase_o  (phase),
    .step_o   (step)
  );

  uop_opdec #(.OPW(OPW)) u_dec (
    .op_i   (ir[DW-2 -: OPW]),
    .op_oh_o(op_oh)
  );

  uop_ctrl #(.OPW(OPW), .STEP_W(STEP_W)) u_ctrl (
    .clk_i, .rst_ni,
    .phase_i  (phase),
    .step_i   (step),
    .op_oh_i  (op_oh),
    .ind_i    (mem_wdata_o[DW-1]),
    .ien_i    (ien_o),
    .irq_i,
    .ctrl_o   (ctrl),
    .next_ph_o(next_ph)
  );

  uop_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk_i, .rst_ni,
    .ctrl_i     (ctrl),
    .mem_rdata_i,
    .mem_addr_o,
    .mem_wdata_o,
    .pc_o,
    .acc_o,
    .ir_o       (ir),
    .ien_o
  );

  assign mem_rd_o = ctrl.mem_rd;
  assign mem_wr_o = ctrl.mem_wr;
  assign phase_o  = phase;

  p_rd_wr_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));

  p_pc_inc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_FETCH && step == STEP_W'(1)) |=> (pc_o == $past(pc_o) + 1'b1));

  p_ind_route_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_FETCH && ctrl.last) |=> (phase == (ir[DW-1] ? PH_INDIR : PH_EXEC)));

  p_intr_entry_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_INTR && ctrl.last) |=> (phase == PH_FETCH && pc_o == AW'(1) && !ien_o));
endmodule

// File: tb/uop_sequencer_test.sv
`timescale 1ns/1ps
module uop_sequencer_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        irq = 1'b0;
  logic [11:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic [1:0]  phase;
  logic [11:0] pc;
  logic [15:0] acc;
  logic        ien;

  int checks = 0;
  int failures = 0;
  int overlap = 0;
  bit done = 0;

  logic [15:0] mem [4096];
  logic [15:0] mm  [4096];
  logic [11:0] mpc;
  logic [15:0] macc;
  logic        mien;
  logic [1:0]  last_ph;
  logic [1:0]  ph_log [64];

  always #2 clk = ~clk;

  uop_sequencer uut (
    .clk_i(clk), .rst_ni(rst_ni), .irq_i(irq),
    .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .phase_o(phase), .pc_o(pc), .acc_o(acc), .ien_o(ien)
  );

  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (rst_ni && mem_rd && mem_wr) overlap <= overlap + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wait_boundary(output int cyc);
    bit hit = 0;
    cyc = 0;
    while (!hit && cyc < 64) begin
      @(negedge clk);
      ph_log[cyc] = phase;
      cyc++;
      hit = (phase == 2'b00) && (last_ph != 2'b00);
      last_ph = phase;
    end
    if (!hit) begin
      failures++;
      $display("FAIL R2 watchdog: no instruction end act=%0d exp<64", cyc);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 reset phase", 32'(phase), 32'h0);
    check("R1 reset pc", 32'(pc), 32'h0);
    check("R1 reset acc", 32'(acc), 32'h0);
    check("R1 reset ien", 32'(ien), 32'h0);
    rst_ni = 1'b1;
    last_ph = 2'b00;
  endtask

  // instruction-level reference: returns expected clock count
  task automatic model_step(input logic irq_lvl, output int cyc);
    logic [15:0] w, v;
    logic [11:0] a;
    logic take;
    w = mm[mpc];
    mpc = mpc + 12'd1;
    a = w[11:0];
    cyc = 4;
    if (w[15]) begin
      a = mm[a][11:0];
      cyc += 4;
    end
    take = mien && irq_lvl;
    case (w[14:12])
      3'd0: begin macc = macc + mm[a]; cyc += 4; end
      3'd1: begin
        v = mm[a] + 16'd1;
        mm[a] = v;
        if (v == 16'd0) mpc = mpc + 12'd1;
        cyc += 5;
      end
      3'd2: begin mm[a] = {4'b0, mpc}; mpc = a + 12'd1; cyc += 2; end
      3'd7: begin mien = 1'b1; cyc += 1; end
      default: cyc += 1;
    endcase
    if (take) begin
      mm[0] = {4'b0, mpc};
      mpc = 12'd1;
      mien = 1'b0;
      cyc += 2;
    end
  endtask

  function automatic logic [15:0] rand_word();
    int r = $urandom % 10;
    logic [2:0] op;
    if (r < 3)      op = 3'd0;
    else if (r < 5) op = 3'd1;
    else if (r < 7) op = 3'd2;
    else if (r < 8) op = 3'd7;
    else            op = 3'(3 + ($urandom % 4));
    return {($urandom % 4) == 0, op, 12'($urandom)};
  endfunction

  task automatic run_random(input logic irq_lvl, input int n);
    int cyc, ecyc, bad;
    for (int i = 0; i < 4096; i++) begin
      mem[i] = rand_word();
      mm[i] = mem[i];
    end
    mpc = '0; macc = '0; mien = 1'b0;
    irq = irq_lvl;
    do_reset();
    for (int k = 0; k < n; k++) begin
      model_step(irq_lvl, ecyc);
      wait_boundary(cyc);
      check("R3 R6 R9 pc", 32'(pc), 32'(mpc));
      check("R4 acc", 32'(acc), 32'(macc));
      check("R8 R9 ien", 32'(ien), 32'(mien));
      check("R2 clocks per instruction", 32'(cyc), 32'(ecyc));
    end
    bad = 0;
    for (int i = 0; i < 4096; i++) if (mem[i] !== mm[i]) bad++;
    check("R5 R6 R9 memory image mismatches", 32'(bad), 32'h0);
  endtask

  task automatic step_dir(input string req, input logic [11:0] epc, input logic [15:0] eacc, input int ecyc);
    int cyc;
    wait_boundary(cyc);
    check({req, " pc"}, 32'(pc), 32'(epc));
    check({req, " acc"}, 32'(acc), 32'(eacc));
    check({req, " clocks"}, 32'(cyc), 32'(ecyc));
  endtask

  task automatic run_directed();
    int bad;
    for (int i = 0; i < 4096; i++) mem[i] = 16'h3000;
    mem[0] = 16'h0100; mem[1] = 16'h0101; mem[2] = 16'h1102; mem[3] = 16'h1102;
    mem[4] = 16'h0100; mem[5] = 16'h8103; mem[6] = 16'h2200;
    mem[12'h100] = 16'h1234; mem[12'h101] = 16'hF000; mem[12'h102] = 16'hFFFE;
    mem[12'h103] = 16'h0104; mem[12'h104] = 16'h0005;
    mem[12'h200] = 16'h0000; mem[12'h201] = 16'h3000; mem[12'h202] = 16'h7000;
    mem[12'h203] = 16'h0100;
    irq = 1'b1;
    do_reset();
    step_dir("R4 add", 12'h001, 16'h1234, 8);
    step_dir("R4 add wrap", 12'h002, 16'h0234, 8);
    step_dir("R5 isz no skip", 12'h003, 16'h0234, 9);
    check("R5 isz written", 32'(mem[12'h102]), 32'h0000FFFF);
    step_dir("R5 isz skip", 12'h005, 16'h0234, 9);
    check("R5 isz wrap to zero", 32'(mem[12'h102]), 32'h0);
    step_dir("R7 indirect add", 12'h006, 16'h0239, 12);
    bad = 0;
    for (int k = 0; k < 11; k++) begin
      logic [1:0] e = (k < 3) ? 2'b00 : (k < 7) ? 2'b01 : 2'b10;
      if (ph_log[k] !== e) bad++;
    end
    check("R1 R7 phase order fetch-indirect-execute", 32'(bad), 32'h0);
    step_dir("R6 bsa", 12'h201, 16'h0239, 6);
    check("R6 return address stored", 32'(mem[12'h200]), 32'h0007);
    step_dir("R8 no-op opcode", 12'h202, 16'h0239, 5);
    step_dir("R8 enable deferred", 12'h203, 16'h0239, 5);
    check("R8 enable set", 32'(ien), 32'h1);
    step_dir("R9 interrupt entry", 12'h001, 16'h146D, 10);
    check("R1 R9 interrupt phase code", 32'({ph_log[7], ph_log[8]}), 32'hF);
    check("R9 saved pc", 32'(mem[0]), 32'h0204);
    check("R9 enable cleared", 32'(ien), 32'h0);
    step_dir("R9 irq ignored while disabled", 12'h002, 16'h046D, 8);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    run_directed();
    run_random(1'b0, 250);
    run_random(1'b1, 250);
    run_random(1'b1, 300);
    run_random(1'b0, 200);
    check("R10 read and write strobes overlap count", 32'(overlap), 32'h0);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule